// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address space with a two-level page table. When a miss is signalled, it captures the virtual page number, the root table page number and the kind of access (read, write, execute, plus a store flag that selects the fault flavour). It then fetches 4-byte table entries through a request/response memory port. Each entry is classified as a pointer to the next table, a leaf or a fault.

A successful walk ends in a one-cycle refill pulse that carries the virtual page, the physical page and the protection bits of the leaf. A failed walk ends in a one-cycle fault pulse with a typed cause. Every leaf maps exactly one 4 KiB page, whatever level it is found at. When translation is switched off, or the hart runs in machine mode, a miss request is ignored and no walk starts.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `fill_valid_o` and `fault_valid_o` are all low.
- R2: A miss request presented while `xlat_on_i` is 0 or `priv_m_i` is 1 is ignored: `busy_o` and `mem_req_o` stay low and no outcome pulse appears.
- R3: In the cycle after a miss is accepted, `busy_o` and `mem_req_o` are high and `mem_addr_o` equals (`root_ppn_i` << 12) + VPN[19:10]·4. The request and its address are held until `mem_rsp_valid_i`.
- R4: An entry (bit0 V, bit1 R, bit2 W, bit3 X, bit4 U, bits 31:10 PPN) with V=1, R=0, W=0, X=0 fetched at level 1 causes a second fetch at (entry PPN << 12) + VPN[9:0]·4.
- R5: A response with `mem_rsp_err_i` high ends the walk with an access fault and no further fetch. The cause is 2'b01 for a store and 2'b00 otherwise (cause bit1 = page fault, bit0 = store).
- R6: An entry with V=0, or with R=0 and W=1, ends the walk with a page fault: cause 2'b11 for a store, 2'b10 otherwise.
- R7: An entry with V=1, R=0, X=0 fetched at level 0 ends the walk with a page fault.
- R8: A leaf (R=1 or X=1) raises a page fault if a read is requested and R=0, a write is requested and W=0, or an execute is requested and X=0.
- R9: A permitted leaf at either level produces a refill with `fill_vpn_o` = the request VPN, `fill_ppn_o` = entry bits 31:10 and `fill_prot_o` = entry bits 4:1 (bit0 R, bit1 W, bit2 X, bit3 U). No alignment check is made on a level-1 leaf.
- R10: `busy_o` stays high from the cycle after acceptance through the single outcome cycle. Exactly one of `fill_valid_o`/`fault_valid_o` pulses, for one cycle, and `busy_o` is low in the cycle after. A miss request during a walk is ignored.
- R11: When an error and an entry word arrive in the same response, the error decides the outcome, whatever the entry bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Translation miss, start request |
| xlat_on_i | input | 1 | Translation mode enabled (0 = bypass) |
| priv_m_i | input | 1 | Hart in machine mode (bypass) |
| root_ppn_i | input | 22 | Root table physical page number |
| vpn_i | input | 20 | Virtual page number to translate |
| acc_rd_i | input | 1 | Read access requested |
| acc_wr_i | input | 1 | Write access requested |
| acc_ex_i | input | 1 | Execute access requested |
| acc_store_i | input | 1 | Request is a store (selects fault type) |
| mem_req_o | output | 1 | Entry fetch request |
| mem_addr_o | output | 34 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Fetch response valid |
| mem_rsp_err_i | input | 1 | Fetch response error |
| mem_rsp_data_i | input | 32 | Fetched entry word |
| busy_o | output | 1 | Walk in progress |
| fill_valid_o | output | 1 | Refill pulse |
| fill_vpn_o | output | 20 | Refill virtual page number |
| fill_ppn_o | output | 22 | Refill physical page number |
| fill_prot_o | output | 4 | Refill protection bits {U,X,W,R} |
| fault_valid_o | output | 1 | Fault pulse |
| fault_cause_o | output | 2 | Fault cause {page, store} |

## Verification
Two decisions meet in the response cycle. The error flag of the memory port and the decoded content of the entry word arrive together, and both could end the walk. The bench's memory model returns an error together with a word that would otherwise be a permitted leaf, and the bench expects an access fault, not a refill. A second overlap comes from a miss request that arrives while a walk is already running. The bench drives it mid-walk with a different page number and judges it by the fetch addresses and the single outcome pulse, both of which must belong to the first request only.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned PPN_W  = 22;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned PTE_W  = 32;
  localparam int unsigned LEVELS = 2;
  localparam int unsigned IDX_W  = VPN_W / LEVELS;
  localparam int unsigned PA_W   = PPN_W + OFS_W;
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  typedef enum logic [1:0] {
    VD_NEXT  = 2'd0,
    VD_LEAF  = 2'd1,
    VD_PAGEF = 2'd2,
    VD_ACCF  = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_e;

  // cause bit1: page fault, bit0: store
  typedef enum logic [1:0] {
    CS_LD_ACC = 2'b00,
    CS_ST_ACC = 2'b01,
    CS_LD_PG  = 2'b10,
    CS_ST_PG  = 2'b11
  } cause_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned P_VPN_W  = VPN_W,
  parameter int unsigned P_PPN_W  = PPN_W,
  parameter int unsigned P_LEVELS = LEVELS
) (
  input  logic [P_PPN_W-1:0]         base_ppn_i,
  input  logic [P_VPN_W-1:0]         vpn_i,
  input  logic [LVL_W-1:0]           level_i,
  output logic [P_PPN_W+OFS_W-1:0]   addr_o
);
  localparam int unsigned L_IDX_W = P_VPN_W / P_LEVELS;
  localparam int unsigned L_PA_W  = P_PPN_W + OFS_W;

  logic [L_IDX_W-1:0] idx [P_LEVELS];

  for (genvar l = 0; l < P_LEVELS; l++) begin : g_idx
    assign idx[l] = vpn_i[l*L_IDX_W +: L_IDX_W];
  end

  logic [L_IDX_W-1:0] sel_idx;
  always_comb begin
    sel_idx = '0;
    for (int l = 0; l < P_LEVELS; l++) begin
      if (level_i == LVL_W'(l)) sel_idx = idx[l];
    end
  end

  // entries are 4 bytes wide
  assign addr_o = {base_ppn_i, {OFS_W{1'b0}}} + L_PA_W'({sel_idx, 2'b00});
endmodule

// File: rtl/ptw_pte_judge.sv
module ptw_pte_judge
  import ptw_pkg::*;
(
  input  logic             err_i,
  input  logic [4:0]       flags_i,   // {U,X,W,R,V}
  input  logic             last_lvl_i,
  input  logic             need_rd_i,
  input  logic             need_wr_i,
  input  logic             need_ex_i,
  output verdict_e         verdict_o
);
  logic v, r, w, x;
  logic unused_u;
  assign v = flags_i[0];
  assign r = flags_i[1];
  assign w = flags_i[2];
  assign x = flags_i[3];
  assign unused_u = flags_i[4];

  logic perm_bad;
  assign perm_bad = (need_rd_i & ~r) | (need_wr_i & ~w) | (need_ex_i & ~x);

  always_comb begin
    if (err_i)                 verdict_o = VD_ACCF;
    else if (!v || (!r && w))  verdict_o = VD_PAGEF;
    else if (!r && !x)         verdict_o = last_lvl_i ? VD_PAGEF : VD_NEXT;
    else if (perm_bad)         verdict_o = VD_PAGEF;
    else                       verdict_o = VD_LEAF;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic              xlat_on_i,
  input  logic              priv_m_i,
  input  logic [PPN_W-1:0]  root_ppn_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic              acc_ex_i,
  input  logic              acc_store_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_err_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              busy_o,
  output logic              fill_valid_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [PPN_W-1:0]  fill_ppn_o,
  output logic [3:0]        fill_prot_o,
  output logic              fault_valid_o,
  output logic [1:0]        fault_cause_o
);
  walk_state_e        state_q;
  logic [PPN_W-1:0]   base_q;
  logic [LVL_W-1:0]   level_q;
  logic [VPN_W-1:0]   vpn_q;
  logic               rd_q, wr_q, ex_q, st_q;
  logic               fault_q;
  logic [1:0]         cause_q;
  logic [PPN_W-1:0]   ppn_q;
  logic [3:0]         prot_q;

  logic               bypass;
  logic               start;
  verdict_e           verdict;
  logic [PPN_W-1:0]   rsp_ppn;
  logic [4:0]         unused_rsv;

  assign bypass     = ~xlat_on_i | priv_m_i;
  assign start      = (state_q == ST_IDLE) & miss_valid_i & ~bypass;
  assign rsp_ppn    = mem_rsp_data_i[PTE_W-1 -: PPN_W];
  assign unused_rsv = mem_rsp_data_i[9:5];

  ptw_addr_gen u_addr (
    .base_ppn_i (base_q),
    .vpn_i      (vpn_q),
    .level_i    (level_q),
    .addr_o     (mem_addr_o)
  );

  ptw_pte_judge u_judge (
    .err_i      (mem_rsp_err_i),
    .flags_i    (mem_rsp_data_i[4:0]),
    .last_lvl_i (level_q == '0),
    .need_rd_i  (rd_q),
    .need_wr_i  (wr_q),
    .need_ex_i  (ex_q),
    .verdict_o  (verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      level_q <= '0;
      vpn_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      ex_q    <= 1'b0;
      st_q    <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= '0;
      ppn_q   <= '0;
      prot_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          base_q  <= root_ppn_i;
          level_q <= LVL_W'(LEVELS - 1);
          vpn_q   <= vpn_i;
          rd_q    <= acc_rd_i;
          wr_q    <= acc_wr_i;
          ex_q    <= acc_ex_i;
          st_q    <= acc_store_i;
        end
        ST_REQ: if (mem_rsp_valid_i) begin
          unique case (verdict)
            VD_NEXT: begin
              base_q  <= rsp_ppn;
              level_q <= level_q - 1'b1;
            end
            VD_ACCF: begin
              state_q <= ST_FIN;
              fault_q <= 1'b1;
              cause_q <= st_q ? CS_ST_ACC : CS_LD_ACC;
            end
            VD_PAGEF: begin
              state_q <= ST_FIN;
              fault_q <= 1'b1;
              cause_q <= st_q ? CS_ST_PG : CS_LD_PG;
            end
            default: begin
              state_q <= ST_FIN;
              fault_q <= 1'b0;
              ppn_q   <= rsp_ppn;
              prot_q  <= mem_rsp_data_i[4:1];
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign mem_req_o     = (state_q == ST_REQ);
  assign fill_valid_o  = (state_q == ST_FIN) & ~fault_q;
  assign fault_valid_o = (state_q == ST_FIN) &  fault_q;
  assign fill_vpn_o    = vpn_q;
  assign fill_ppn_o    = ppn_q;
  assign fill_prot_o   = prot_q;
  assign fault_cause_o = cause_q;

  p_bypass_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && miss_valid_i && (!xlat_on_i || priv_m_i)) |=> !busy_o);

  p_fetch_on_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_err_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rsp_valid_i && mem_rsp_err_i) |=> (fault_valid_o && !fault_cause_o[1]));

  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_valid_o));

  p_pulse_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_valid_o) |=> (!fill_valid_o && !fault_valid_o && !busy_o));

  p_outcome_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_valid_o) |-> busy_o);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        xlat_on = 1'b1;
  logic        priv_m = 1'b0;
  logic [21:0] root_ppn = '0;
  logic [19:0] vpn = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0, acc_ex = 1'b0, acc_st = 1'b0;
  logic        mem_req;
  logic [33:0] mem_addr;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        busy, fill_valid, fault_valid;
  logic [19:0] fill_vpn;
  logic [21:0] fill_ppn;
  logic [3:0]  fill_prot;
  logic [1:0]  fault_cause;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(miss_valid), .xlat_on_i(xlat_on),
    .priv_m_i(priv_m), .root_ppn_i(root_ppn), .vpn_i(vpn), .acc_rd_i(acc_rd),
    .acc_wr_i(acc_wr), .acc_ex_i(acc_ex), .acc_store_i(acc_st),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_err_i(rsp_err), .mem_rsp_data_i(rsp_data), .busy_o(busy),
    .fill_valid_o(fill_valid), .fill_vpn_o(fill_vpn), .fill_ppn_o(fill_ppn),
    .fill_prot_o(fill_prot), .fault_valid_o(fault_valid), .fault_cause_o(fault_cause)
  );

  // memory model: two programmed entries, anything else answers with error
  logic [33:0] m_a1, m_a0;
  logic [31:0] m_d1, m_d0;
  logic        m_e1, m_e0;
  int          n_req;
  logic [33:0] seen [4];

  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_valid = 1'b0;
      rsp_err   = 1'b0;
    end else if (mem_req) begin
      if (n_req < 4) seen[n_req] = mem_addr;
      n_req++;
      rsp_valid = 1'b1;
      if (mem_addr == m_a1)      begin rsp_data = m_d1; rsp_err = m_e1; end
      else if (mem_addr == m_a0) begin rsp_data = m_d0; rsp_err = m_e0; end
      else                       begin rsp_data = '0;   rsp_err = 1'b1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [21:0] p, input logic u,
      input logic x, input logic w, input logic r, input logic v);
    return {p, 5'b0, u, x, w, r, v};
  endfunction

  function automatic logic [33:0] l1_addr(input logic [21:0] root, input logic [19:0] va);
    return {root, 12'h000} + 34'(va[19:10]) * 34'd4;
  endfunction

  function automatic logic [33:0] l0_addr(input logic [21:0] base, input logic [19:0] va);
    return {base, 12'h000} + 34'(va[9:0]) * 34'd4;
  endfunction

  // outcome capture
  int          got_kind;  // 0 none, 1 fill, 2 fault
  logic [1:0]  got_cause;
  logic [21:0] got_ppn;
  logic [3:0]  got_prot;
  logic [19:0] got_vpn;

  task automatic walk(input logic [21:0] root, input logic [19:0] va,
                      input bit r, input bit w, input bit x, input bit st,
                      input bit extra_start, input string req);
    n_req = 0;
    got_kind = 0;
    @(negedge clk);
    root_ppn = root; vpn = va;
    acc_rd = r; acc_wr = w; acc_ex = x; acc_st = st;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy === 1'b1 && mem_req === 1'b1, "R10", "busy/req after start",
        {busy, mem_req}, 2'b11);
    for (int i = 0; i < 40; i++) begin
      if (fill_valid || fault_valid) begin
        got_kind  = fill_valid ? 1 : 2;
        got_cause = fault_cause;
        got_ppn   = fill_ppn;
        got_prot  = fill_prot;
        got_vpn   = fill_vpn;
        break;
      end
      if (extra_start && i == 0) begin
        vpn = ~va; root_ppn = ~root; miss_valid = 1'b1;
      end else begin
        miss_valid = 1'b0;
      end
      if (!busy) begin
        chk(1'b0, "R10", "busy dropped before outcome", busy, 1);
        break;
      end
      @(negedge clk);
    end
    miss_valid = 1'b0;
    chk(got_kind != 0, req, "outcome seen", got_kind, 1);
    @(negedge clk);
    chk(!fill_valid && !fault_valid && !busy, "R10", "single pulse then idle",
        {fill_valid, fault_valid, busy}, 3'b000);
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !fill_valid && !fault_valid, "R1", "reset outputs",
        {busy, mem_req, fill_valid, fault_valid}, 4'b0000);
  endtask

  task automatic t_bypass;
    for (int k = 0; k < 2; k++) begin
      n_req = 0;
      @(negedge clk);
      xlat_on = (k == 1); priv_m = (k == 1);
      acc_rd = 1'b1; vpn = 20'h12345; root_ppn = 22'h00100;
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
        chk(!busy && !mem_req && !fill_valid && !fault_valid, "R2", "bypass idle",
            {busy, mem_req, fill_valid, fault_valid}, 4'b0000);
        @(negedge clk);
      end
      chk(n_req == 0, "R2", "no fetch in bypass", n_req, 0);
    end
    xlat_on = 1'b1; priv_m = 1'b0;
  endtask

  task automatic t_two_level_read;
    logic [19:0] va = 20'hABCDE;
    logic [21:0] root = 22'h01234, mid = 22'h02A5A, leaf = 22'h3F00F;
    m_a1 = l1_addr(root, va); m_d1 = mk_pte(mid, 0, 0, 0, 0, 1); m_e1 = 0;
    m_a0 = l0_addr(mid, va);  m_d0 = mk_pte(leaf, 1, 0, 1, 1, 1); m_e0 = 0;
    walk(root, va, 1, 0, 0, 0, 0, "R9");
    chk(seen[0] == m_a1, "R3", "level1 address", seen[0], m_a1);
    chk(seen[1] == m_a0, "R4", "level0 address", seen[1], m_a0);
    chk(got_kind == 1, "R9", "fill kind", got_kind, 1);
    chk(got_vpn == va && got_ppn == leaf, "R9", "fill vpn/ppn",
        {got_vpn, got_ppn}, {va, leaf});
    chk(got_prot == 4'b1011, "R9", "fill prot", got_prot, 4'b1011);
  endtask

  task automatic t_level1_leaf;
    logic [19:0] va = 20'h00401;
    logic [21:0] root = 22'h00ABC, leaf = 22'h155A3;
    m_a1 = l1_addr(root, va); m_d1 = mk_pte(leaf, 0, 1, 0, 0, 1); m_e1 = 0;
    m_a0 = '1; m_d0 = '0; m_e0 = 1;
    walk(root, va, 0, 0, 1, 0, 0, "R9");
    chk(n_req == 1, "R9", "single fetch for level1 leaf", n_req, 1);
    chk(got_kind == 1 && got_ppn == leaf && got_prot == 4'b0100, "R9",
        "level1 leaf fill", {got_kind[1:0], got_ppn, got_prot}, {2'd1, leaf, 4'b0100});
  endtask

  task automatic t_access_faults;
    logic [19:0] va = 20'h7F3C2;
    logic [21:0] root = 22'h00777, mid = 22'h00888;
    m_a1 = l1_addr(root, va); m_d1 = '0; m_e1 = 1;
    m_a0 = '1; m_e0 = 1; m_d0 = '0;
    walk(root, va, 1, 0, 0, 0, 0, "R5");
    chk(got_kind == 2 && got_cause == 2'b00, "R5", "load access fault",
        {got_kind[1:0], got_cause}, {2'd2, 2'b00});
    chk(n_req == 1, "R5", "no refetch after error", n_req, 1);
    walk(root, va, 0, 1, 0, 1, 0, "R5");
    chk(got_kind == 2 && got_cause == 2'b01, "R5", "store access fault",
        {got_kind[1:0], got_cause}, {2'd2, 2'b01});
    m_e1 = 0; m_d1 = mk_pte(mid, 0, 0, 0, 0, 1);
    m_a0 = l0_addr(mid, va); m_e0 = 1;
    walk(root, va, 1, 0, 0, 0, 0, "R5");
    chk(got_kind == 2 && got_cause == 2'b00 && n_req == 2, "R5", "level0 access fault",
        {got_kind[1:0], got_cause, 8'(n_req)}, {2'd2, 2'b00, 8'd2});
  endtask

  task automatic t_invalid;
    logic [19:0] va = 20'h0F0F0;
    logic [21:0] root = 22'h00345;
    m_a1 = l1_addr(root, va); m_e1 = 0; m_a0 = '1; m_e0 = 1;
    m_d1 = mk_pte(22'h12345, 1, 1, 1, 1, 0);
    walk(root, va, 1, 0, 0, 0, 0, "R6");
    chk(got_kind == 2 && got_cause == 2'b10, "R6", "V=0 load page fault",
        {got_kind[1:0], got_cause}, {2'd2, 2'b10});
    m_d1 = mk_pte(22'h12345, 0, 0, 1, 0, 1);
    walk(root, va, 0, 1, 0, 1, 0, "R6");
    chk(got_kind == 2 && got_cause == 2'b11, "R6", "R0W1 store page fault",
        {got_kind[1:0], got_cause}, {2'd2, 2'b11});
  endtask

  task automatic t_pointer_at_l0;
    logic [19:0] va = 20'h3C3C3;
    logic [21:0] root = 22'h00111, mid = 22'h00222;
    m_a1 = l1_addr(root, va); m_d1 = mk_pte(mid, 0, 0, 0, 0, 1); m_e1 = 0;
    m_a0 = l0_addr(mid, va);  m_d0 = mk_pte(22'h00333, 0, 0, 0, 0, 1); m_e0 = 0;
    walk(root, va, 1, 0, 0, 0, 0, "R7");
    chk(got_kind == 2 && got_cause == 2'b10 && n_req == 2, "R7", "pointer at level 0",
        {got_kind[1:0], got_cause, 8'(n_req)}, {2'd2, 2'b10, 8'd2});
  endtask

  task automatic t_perms;
    logic [19:0] va = 20'h55AA5;
    logic [21:0] root = 22'h00999;
    m_a1 = l1_addr(root, va); m_e1 = 0; m_a0 = '1; m_e0 = 1;
    m_d1 = mk_pte(22'h00ABC, 0, 1, 0, 1, 1);  // R,X no W
    walk(root, va, 0, 1, 0, 1, 0, "R8");
    chk(got_kind == 2 && got_cause == 2'b11, "R8", "write without W",
        {got_kind[1:0], got_cause}, {2'd2, 2'b11});
    m_d1 = mk_pte(22'h00ABC, 0, 0, 1, 1, 1);  // R,W no X
    walk(root, va, 0, 0, 1, 0, 0, "R8");
    chk(got_kind == 2 && got_cause == 2'b10, "R8", "execute without X",
        {got_kind[1:0], got_cause}, {2'd2, 2'b10});
    m_d1 = mk_pte(22'h00ABC, 0, 1, 0, 0, 1);  // X only
    walk(root, va, 1, 0, 0, 0, 0, "R8");
    chk(got_kind == 2 && got_cause == 2'b10, "R8", "read without R",
        {got_kind[1:0], got_cause}, {2'd2, 2'b10});
  endtask

  task automatic t_err_with_leaf;
    logic [19:0] va = 20'h11111;
    logic [21:0] root = 22'h00444;
    m_a1 = l1_addr(root, va); m_d1 = mk_pte(22'h00555, 1, 1, 1, 1, 1); m_e1 = 1;
    m_a0 = '1; m_e0 = 1;
    walk(root, va, 1, 0, 0, 0, 0, "R11");
    chk(got_kind == 2 && got_cause == 2'b00, "R11", "error beats valid leaf",
        {got_kind[1:0], got_cause}, {2'd2, 2'b00});
  endtask

  task automatic t_start_while_busy;
    logic [19:0] va = 20'h2468A;
    logic [21:0] root = 22'h00666, mid = 22'h00676, leaf = 22'h0ABCD;
    m_a1 = l1_addr(root, va); m_d1 = mk_pte(mid, 0, 0, 0, 0, 1); m_e1 = 0;
    m_a0 = l0_addr(mid, va);  m_d0 = mk_pte(leaf, 0, 0, 0, 1, 1); m_e0 = 0;
    walk(root, va, 1, 0, 0, 0, 1, "R10");
    chk(seen[1] == m_a0 && n_req == 2, "R10", "second fetch of first walk",
        {seen[1], 8'(n_req)}, {m_a0, 8'd2});
    chk(got_kind == 1 && got_vpn == va, "R10", "fill of first walk only",
        {got_kind[1:0], got_vpn}, {2'd1, va});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy, "R10", "no walk from ignored request", busy, 0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_two_level_read();
        t_level1_leaf();
        t_access_faults();
        t_invalid();
        t_pointer_at_l0();
        t_perms();
        t_err_with_leaf();
        t_start_while_busy();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule